// File: doc/BRIEF.md
# CRT Controller Host Register Port

This block is the processor-facing side of a character-cell CRT controller. A processor reaches it through a chip select, a register-select line, a read/write line and an 8-bit data bus. With register-select low, a write sets a 5-bit index and a read returns a status byte. With register-select high, the access goes to the register the index points at. The stored values leave the block on wide, width-trimmed ports for the raster timing generator and the memory update controller.

The block also keeps a light pen capture latch. A rising edge on the pen strobe copies the current 14-bit refresh address. Reading either half of that latch clears both the pen-full flag and the update-ready flag. A 14-bit update address, written in two halves, advances by one on each completed memory update. Any access to index 31 asks the update controller for one transparent memory cycle.

Top module: `crtc_host_regs`

## Requirements
- R1: With cs_i high, rs_i low and rw_i low (rw_i=1 means read, 0 means write), bits 4:0 of wr_data_i load the index. Later accesses with rs_i high go to the register that index selects. The index and all registers reset to 0.
- R2: A read with rs_i low returns the status byte. Bit 5 follows vblank_i, bit 6 is the pen-full flag, bit 7 is update-ready, and bits 4:0 read 0.
- R3: A rising edge on lpen_strobe_i while pen-full is clear stores mem_addr_i and sets pen-full. Index 16 reads {2'b0, addr[13:8]} and index 17 reads addr[7:0]. While pen-full is set, further edges leave the stored address unchanged.
- R4: A read of index 16 or 17 clears pen-full and update-ready, starting with the next cycle.
- R5: A one-cycle pulse on update_done_i sets update-ready and adds 1 to update_addr_o. The sum wraps modulo 2^14, so 3FFF becomes 0000.
- R6: A read or write with rs_i high at index 31 raises update_req_o for exactly the following cycle.
- R7: Data writes are trimmed to register width. Indexes 0,1,2,3,8 and 13,15 keep 8 bits. Indexes 4,6,7,10 keep 7 bits. Indexes 5,9,11 keep 5 bits. Indexes 12 and 14 keep 6 bits. Index 12/13 drive disp_start_o[13:8]/[7:0], and index 14/15 drive cursor_addr_o[13:8]/[7:0].
- R8: Only indexes 14 to 17 are readable. A data read at any other index returns 0, and rd_data_o is 0 whenever no read is in progress.
- R9: Data writes to indexes 16, 17 and 20 to 30 change no register or exported value.
- R10: Writes to index 18 (6 bits) and index 19 (8 bits) set update_addr_o to {idx18, idx19}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, one access per cycle while high |
| rs_i | input | 1 | 0: index/status, 1: data register |
| rw_i | input | 1 | 1 read, 0 write |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data, combinational during a read |
| lpen_strobe_i | input | 1 | Light pen strobe |
| mem_addr_i | input | 14 | Current refresh address |
| vblank_i | input | 1 | Scan is in vertical blanking |
| update_done_i | input | 1 | Update cycle completed |
| h_total_o | output | 8 | Index 0 |
| h_disp_o | output | 8 | Index 1 |
| h_sync_pos_o | output | 8 | Index 2 |
| sync_width_o | output | 8 | Index 3 |
| v_total_o | output | 7 | Index 4 |
| v_adjust_o | output | 5 | Index 5 |
| v_disp_o | output | 7 | Index 6 |
| v_sync_pos_o | output | 7 | Index 7 |
| mode_o | output | 8 | Index 8 |
| raster_max_o | output | 5 | Index 9 |
| cursor_start_o | output | 7 | Index 10 |
| cursor_end_o | output | 5 | Index 11 |
| disp_start_o | output | 14 | Indexes 12/13 |
| cursor_addr_o | output | 14 | Indexes 14/15 |
| update_addr_o | output | 14 | Indexes 18/19, post-incremented |
| update_req_o | output | 1 | Update request pulse |

## Verification
A wrong index latch sends every later data write to the wrong register. This shows on the exported ports in the cycle after the write. A stuck pen or update flag shows in bit 6 or 7 of the next status read. An early clear shows as a second capture overwriting the first address. A broken increment or a bad trim mask shows in update_addr_o or the exported value one cycle after the pulse or write.

// File: rtl/crtc_host_pkg.sv
package crtc_host_pkg;
  localparam int unsigned DW       = 8;
  localparam int unsigned IDX_W    = 5;
  localparam int unsigned AW       = 14;
  localparam int unsigned N_PLAIN  = 16;
  localparam int unsigned IDX_PEN_HI = 16;
  localparam int unsigned IDX_PEN_LO = 17;
  localparam int unsigned IDX_UPD_HI = 18;
  localparam int unsigned IDX_UPD_LO = 19;
  localparam int unsigned IDX_TRIG   = 31;

  // storage mask per plain register index (R7)
  function automatic logic [DW-1:0] reg_mask(input int unsigned idx);
    case (idx)
      4, 6, 7, 10: reg_mask = 8'h7f;
      5, 9, 11:    reg_mask = 8'h1f;
      12, 14:      reg_mask = 8'h3f;
      default:     reg_mask = 8'hff;
    endcase
  endfunction
endpackage

// File: rtl/crtc_reg_file.sv
module crtc_reg_file
  import crtc_host_pkg::*;
#(
  parameter int unsigned NREG = N_PLAIN
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [NREG-1:0][DW-1:0]   regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DW-1:0] MASK = reg_mask(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_o[g] <= '0;
      else if (we_i && idx_i == IDX_W'(g))       regs_o[g] <= wdata_i & MASK;
    end
  end

  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx_i >= IDX_W'(NREG)) |=> $stable(regs_o)); // R9
endmodule

// File: rtl/crtc_lpen_cap.sv
module crtc_lpen_cap
  import crtc_host_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  input  logic [AW-1:0] mem_addr_i,
  input  logic          clr_i,
  output logic          full_o,
  output logic [AW-1:0] addr_o
);
  logic strobe_q;
  logic edge_hit;

  assign edge_hit = strobe_i && !strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      full_o   <= 1'b0;
      addr_o   <= '0;
    end else begin
      strobe_q <= strobe_i;
      if (edge_hit && !full_o) begin
        full_o <= 1'b1;
        addr_o <= mem_addr_i;
      end else if (clr_i) begin
        full_o <= 1'b0;
      end
    end
  end

  AST_LPEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> $stable(addr_o)); // R3
  AST_LPEN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(edge_hit && !full_o)) |=> !full_o); // R4
endmodule

// File: rtl/crtc_update_ctl.sv
module crtc_update_ctl
  import crtc_host_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_hi_i,
  input  logic          wr_lo_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          trig_i,
  input  logic          done_i,
  input  logic          clr_i,
  output logic [AW-1:0] addr_o,
  output logic          req_o,
  output logic          ready_o
);
  localparam int unsigned HI_W = AW - DW;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      req_o   <= 1'b0;
      ready_o <= 1'b0;
    end else begin
      req_o <= trig_i;
      if (wr_hi_i)      addr_o[AW-1:DW] <= wdata_i[HI_W-1:0];
      else if (wr_lo_i) addr_o[DW-1:0]  <= wdata_i;
      else if (done_i)  addr_o          <= addr_o + AW'(1);
      if (done_i)       ready_o <= 1'b1;
      else if (clr_i)   ready_o <= 1'b0;
    end
  end

  AST_UPD_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !wr_hi_i && !wr_lo_i) |=> addr_o == $past(addr_o) + AW'(1)); // R5
  AST_REQ_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(trig_i)); // R6
endmodule

// File: rtl/crtc_host_regs.sv
module crtc_host_regs
  import crtc_host_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cs_i,
  input  logic        rs_i,
  input  logic        rw_i,
  input  logic [7:0]  wr_data_i,
  output logic [7:0]  rd_data_o,
  input  logic        lpen_strobe_i,
  input  logic [13:0] mem_addr_i,
  input  logic        vblank_i,
  input  logic        update_done_i,
  output logic [7:0]  h_total_o,
  output logic [7:0]  h_disp_o,
  output logic [7:0]  h_sync_pos_o,
  output logic [7:0]  sync_width_o,
  output logic [6:0]  v_total_o,
  output logic [4:0]  v_adjust_o,
  output logic [6:0]  v_disp_o,
  output logic [6:0]  v_sync_pos_o,
  output logic [7:0]  mode_o,
  output logic [4:0]  raster_max_o,
  output logic [6:0]  cursor_start_o,
  output logic [4:0]  cursor_end_o,
  output logic [13:0] disp_start_o,
  output logic [13:0] cursor_addr_o,
  output logic [13:0] update_addr_o,
  output logic        update_req_o
);
  logic [IDX_W-1:0]           idx_q;
  logic [N_PLAIN-1:0][DW-1:0] regs;
  logic                       wr_data, rd_data, pen_rd;
  logic                       pen_full, upd_ready;
  logic [AW-1:0]              pen_addr;

  assign wr_data = cs_i && rs_i && !rw_i;
  assign rd_data = cs_i && rs_i && rw_i;
  assign pen_rd  = rd_data && (idx_q == IDX_W'(IDX_PEN_HI) || idx_q == IDX_W'(IDX_PEN_LO));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     idx_q <= '0;
    else if (cs_i && !rs_i && !rw_i) idx_q <= wr_data_i[IDX_W-1:0];
  end

  crtc_reg_file #(.NREG(N_PLAIN)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_data),
    .idx_i   (idx_q),
    .wdata_i (wr_data_i),
    .regs_o  (regs)
  );

  crtc_lpen_cap u_lpen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (lpen_strobe_i),
    .mem_addr_i (mem_addr_i),
    .clr_i      (pen_rd),
    .full_o     (pen_full),
    .addr_o     (pen_addr)
  );

  crtc_update_ctl u_upd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_hi_i (wr_data && idx_q == IDX_W'(IDX_UPD_HI)),
    .wr_lo_i (wr_data && idx_q == IDX_W'(IDX_UPD_LO)),
    .wdata_i (wr_data_i),
    .trig_i  (cs_i && rs_i && idx_q == IDX_W'(IDX_TRIG)),
    .done_i  (update_done_i),
    .clr_i   (pen_rd),
    .addr_o  (update_addr_o),
    .req_o   (update_req_o),
    .ready_o (upd_ready)
  );

  always_comb begin
    rd_data_o = '0;
    if (cs_i && rw_i) begin
      if (!rs_i) rd_data_o = {upd_ready, pen_full, vblank_i, 5'b0};
      else begin
        case (idx_q)
          5'd14:   rd_data_o = regs[14];
          5'd15:   rd_data_o = regs[15];
          5'd16:   rd_data_o = {2'b0, pen_addr[13:8]};
          5'd17:   rd_data_o = pen_addr[7:0];
          default: rd_data_o = '0;
        endcase
      end
    end
  end

  assign h_total_o      = regs[0];
  assign h_disp_o       = regs[1];
  assign h_sync_pos_o   = regs[2];
  assign sync_width_o   = regs[3];
  assign v_total_o      = regs[4][6:0];
  assign v_adjust_o     = regs[5][4:0];
  assign v_disp_o       = regs[6][6:0];
  assign v_sync_pos_o   = regs[7][6:0];
  assign mode_o         = regs[8];
  assign raster_max_o   = regs[9][4:0];
  assign cursor_start_o = regs[10][6:0];
  assign cursor_end_o   = regs[11][4:0];
  assign disp_start_o   = {regs[12][5:0], regs[13]};
  assign cursor_addr_o  = {regs[14][5:0], regs[15]};

  AST_STATUS_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rw_i && !rs_i) |-> rd_data_o[4:0] == 5'b0); // R2
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && rw_i) |-> rd_data_o == 8'h00); // R8
  AST_INDEX_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !rs_i && !rw_i) |=> idx_q == $past(wr_data_i[IDX_W-1:0])); // R1
endmodule

// File: tb/crtc_host_regs_tb_top.sv
module crtc_host_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_i = 1'b0, rs_i = 1'b0, rw_i = 1'b0;
  logic [7:0]  wr_data_i = '0;
  logic [7:0]  rd_data_o;
  logic        lpen_strobe_i = 1'b0;
  logic [13:0] mem_addr_i = '0;
  logic        vblank_i = 1'b0;
  logic        update_done_i = 1'b0;
  logic [7:0]  h_total_o, h_disp_o, h_sync_pos_o, sync_width_o, mode_o;
  logic [6:0]  v_total_o, v_disp_o, v_sync_pos_o, cursor_start_o;
  logic [4:0]  v_adjust_o, raster_max_o, cursor_end_o;
  logic [13:0] disp_start_o, cursor_addr_o, update_addr_o;
  logic        update_req_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  crtc_host_regs dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs_i), .rs_i(rs_i), .rw_i(rw_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .lpen_strobe_i(lpen_strobe_i),
    .mem_addr_i(mem_addr_i), .vblank_i(vblank_i), .update_done_i(update_done_i),
    .h_total_o(h_total_o), .h_disp_o(h_disp_o), .h_sync_pos_o(h_sync_pos_o),
    .sync_width_o(sync_width_o), .v_total_o(v_total_o), .v_adjust_o(v_adjust_o),
    .v_disp_o(v_disp_o), .v_sync_pos_o(v_sync_pos_o), .mode_o(mode_o),
    .raster_max_o(raster_max_o), .cursor_start_o(cursor_start_o),
    .cursor_end_o(cursor_end_o), .disp_start_o(disp_start_o),
    .cursor_addr_o(cursor_addr_o), .update_addr_o(update_addr_o),
    .update_req_o(update_req_o)
  );

  // {index, write data, expected exported byte}
  localparam logic [20:0] VEC [16] = '{
    {5'd0,  8'hff, 8'hff}, {5'd1,  8'h50, 8'h50}, {5'd2,  8'h62, 8'h62},
    {5'd3,  8'ha8, 8'ha8}, {5'd4,  8'hff, 8'h7f}, {5'd5,  8'hff, 8'h1f},
    {5'd6,  8'hff, 8'h7f}, {5'd7,  8'h80, 8'h00}, {5'd8,  8'hc5, 8'hc5},
    {5'd9,  8'hff, 8'h1f}, {5'd10, 8'hff, 8'h7f}, {5'd11, 8'he3, 8'h03},
    {5'd12, 8'hff, 8'h3f}, {5'd13, 8'ha5, 8'ha5}, {5'd14, 8'hff, 8'h3f},
    {5'd15, 8'h3c, 8'h3c}
  };

  function automatic logic [7:0] exported(input logic [4:0] idx);
    case (idx)
      5'd0:  return h_total_o;
      5'd1:  return h_disp_o;
      5'd2:  return h_sync_pos_o;
      5'd3:  return sync_width_o;
      5'd4:  return {1'b0, v_total_o};
      5'd5:  return {3'b0, v_adjust_o};
      5'd6:  return {1'b0, v_disp_o};
      5'd7:  return {1'b0, v_sync_pos_o};
      5'd8:  return mode_o;
      5'd9:  return {3'b0, raster_max_o};
      5'd10: return {1'b0, cursor_start_o};
      5'd11: return {3'b0, cursor_end_o};
      5'd12: return {2'b0, disp_start_o[13:8]};
      5'd13: return disp_start_o[7:0];
      5'd14: return {2'b0, cursor_addr_o[13:8]};
      default: return cursor_addr_o[7:0];
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one bus cycle; q holds read data sampled mid-cycle
  task automatic bus(input logic rs, input logic rw, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    cs_i = 1'b1; rs_i = rs; rw_i = rw; wr_data_i = d;
    #1 q = rd_data_o;
    @(negedge clk);
    cs_i = 1'b0; rs_i = 1'b0; rw_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic set_idx(input logic [7:0] i);
    logic [7:0] q;
    bus(1'b0, 1'b0, i, q);
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [7:0] d);
    logic [7:0] q;
    set_idx(i);
    bus(1'b1, 1'b0, d, q);
  endtask

  task automatic rd_reg(input logic [7:0] i, output logic [7:0] q);
    set_idx(i);
    bus(1'b1, 1'b1, 8'h00, q);
  endtask

  task automatic rd_status(output logic [7:0] q);
    bus(1'b0, 1'b1, 8'h00, q);
  endtask

  task automatic pen_edge(input logic [13:0] a);
    @(negedge clk); mem_addr_i = a; lpen_strobe_i = 1'b1;
    @(negedge clk); lpen_strobe_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic done_pulse();
    @(negedge clk); update_done_i = 1'b1;
    @(negedge clk); update_done_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    logic [13:0] snap_c, snap_d, snap_u;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R11-style reset checks tied to R1 and R2
    check("R1 reset export", {h_total_o, cursor_addr_o, update_addr_o}, '0);
    rd_status(q);
    check("R2 reset status", q, 8'h00);
    check("R8 idle bus", rd_data_o, 8'h00);

    // R7 vector walk over plain registers
    for (int i = 0; i < 16; i++) begin
      wr_reg({3'b0, VEC[i][20:16]}, VEC[i][15:8]);
      check("R7 width/export", exported(VEC[i][20:16]), VEC[i][7:0]);
    end

    // R1 index selects target: readback of 14/15
    rd_reg(8'd14, q); check("R1 rd idx14", q, 8'h3f);
    rd_reg(8'd15, q); check("R1 rd idx15", q, 8'h3c);
    // R8 non-readable registers
    rd_reg(8'd0, q);  check("R8 rd idx0", q, 8'h00);
    rd_reg(8'd13, q); check("R8 rd idx13", q, 8'h00);

    // R10 update address
    wr_reg(8'd18, 8'hff);
    wr_reg(8'd19, 8'hfe);
    check("R10 upd addr", update_addr_o, 14'h3ffe);
    rd_reg(8'd18, q); check("R8 rd idx18", q, 8'h00);

    // R5 increment and wrap, ready flag
    done_pulse(); check("R5 inc", update_addr_o, 14'h3fff);
    done_pulse(); check("R5 wrap", update_addr_o, 14'h0000);
    rd_status(q); check("R5 ready bit7", q, 8'h80);

    // R2 vblank reflection
    vblank_i = 1'b1;
    rd_status(q); check("R2 vblank set", q, 8'ha0);
    vblank_i = 1'b0;

    // R3 capture and hold
    pen_edge(14'h2a5c);
    rd_status(q); check("R3 full bit6", q, 8'hc0);
    pen_edge(14'h1111);
    rd_reg(8'd17, q); check("R3 lo byte", q, 8'h5c);
    // R4 clear after read of 17
    rd_status(q); check("R4 flags cleared", q, 8'h00);
    rd_reg(8'd16, q); check("R3 hi byte held", q, 8'h2a);
    pen_edge(14'h1111);
    rd_reg(8'd16, q); check("R3 recapture hi", q, 8'h11);
    rd_status(q); check("R4 cleared by 16", q, 8'h00);

    // R6 update request pulse
    set_idx(8'd31);
    @(negedge clk); cs_i = 1'b1; rs_i = 1'b1; rw_i = 1'b1;
    @(negedge clk); cs_i = 1'b0; rs_i = 1'b0; rw_i = 1'b0;
    check("R6 req high", update_req_o, 1'b1);
    @(negedge clk);
    check("R6 req one cycle", update_req_o, 1'b0);
    bus(1'b1, 1'b0, 8'h00, q);
    check("R6 write trig", update_req_o, 1'b1);

    // R9 ignored writes
    snap_c = cursor_addr_o; snap_d = disp_start_o; snap_u = update_addr_o;
    wr_reg(8'd25, 8'h77);
    wr_reg(8'd16, 8'h77);
    wr_reg(8'd30, 8'h77);
    check("R9 cursor kept", cursor_addr_o, snap_c);
    check("R9 start kept", disp_start_o, snap_d);
    check("R9 upd kept", update_addr_o, snap_u);
    check("R9 hdr kept", {h_total_o, mode_o}, {8'hff, 8'hc5});
    rd_reg(8'd17, q); check("R9 pen kept", q, 8'h11);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule